// File: doc/BRIEF.md
# Quadrature encoder front end

This block sits between the three pins of a rotary incremental encoder (two phase lines and an index line) and a position or speed counter elsewhere on the chip. Each pin can be inverted on its own. The two phase lines can be exchanged. The index can be taken from its own pin or from the pin that normally carries the second phase. Every conditioned line passes through a synchronizer and then a glitch filter whose minimum pulse width is set at run time.

The decoder tracks the Gray-code state of the two phases. It emits one-cycle count-up and count-down strobes and keeps a direction bit. In transparent mode it skips direction logic and only reports edges. It also watches for illegal two-state jumps, which it treats as missing pulses. It can emit a corrective count for each such jump, and it raises a sticky flag once a programmable number of consecutive misses has been seen.

Configuration is one word loaded through a write strobe. The position counter and the speed time base are outside this block.

Top module: `qenc_front`

## Requirements
- R1: After reset, `cnt_up`, `cnt_dn`, `idx_pulse` and `miss_flag` are low, `dir_fwd` is high, and the configuration word is zero, so the decoder is off.
- R2: When `cfg_we` is high at a rising edge, `cfg_wdata` is loaded. The fields are: bit 0 decoder enable, bit 1 edge mode, bit 2 transparent mode, bit 3 phase swap, bit 4 invert phase A, bit 5 invert phase B, bit 6 invert index, bit 7 index select, bit 8 miss handling enable, bits 14:9 filter length L, bits 18:15 miss threshold.
- R3: The invert bits flip the corresponding pin. The swap bit then exchanges the two already-inverted phases before synchronizing, filtering and decoding.
- R4: A level change reaches the decoder only after it has been present on L+1 consecutive clock samples. A pulse of L samples or fewer is discarded.
- R5: A pin change held long enough produces its strobe in the cycle after the (4+L)-th rising edge, counting the first edge that samples the new level as edge one.
- R6: With the conditioned pair (A,B), the order 00, 01, 11, 10, 00 is forward and pulses `cnt_up`; the reverse order pulses `cnt_dn`. `dir_fwd` follows the last legal step. `cnt_up` and `cnt_dn` are never high together.
- R7: With edge mode 0, only transitions that change A produce a strobe. With edge mode 1, every legal transition produces a strobe.
- R8: In transparent mode, each selected edge pulses `cnt_up` only, `cnt_dn` stays low, `dir_fwd` holds, and jumps are not treated as misses.
- R9: The index source is the index pin when bit 7 is 0 and the raw phase B pin when bit 7 is 1, after optional inversion. Each rising edge of the filtered index gives one single-cycle `idx_pulse`.
- R10: While the enable bit is 0, no strobe or index pulse is produced and the consecutive-miss run is cleared.
- R11: A jump of two Gray states is a missing pulse. When bit 8 is 1, it emits exactly one strobe in the `dir_fwd` direction and counts toward the threshold. When bit 8 is 0, it produces no strobe and no miss.
- R12: `miss_flag` sets when the run of consecutive misses reaches a nonzero threshold. A threshold of 0 never sets the flag. Every legal step clears the run.
- R13: `miss_flag` stays high until `miss_clr` is seen at a rising edge. A flag-setting miss in the same cycle as `miss_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9+FILT_W+MISS_W (19) | Configuration word |
| miss_clr | input | 1 | Clears the missing-pulse flag |
| enc_a | input | 1 | Encoder phase A pin |
| enc_b | input | 1 | Encoder phase B pin |
| enc_idx | input | 1 | Encoder index pin |
| cnt_up | output | 1 | One-cycle forward count strobe |
| cnt_dn | output | 1 | One-cycle backward count strobe |
| idx_pulse | output | 1 | One-cycle index strobe |
| dir_fwd | output | 1 | Current direction, 1 = forward |
| miss_flag | output | 1 | Sticky consecutive missing-pulse flag |

## Verification
The case that needs care is a flag-raising jump arriving in the same cycle as a flag clear. The bench places the two-phase jump on the pins, counts 3+L rising edges, and raises `miss_clr` for exactly the cycle in which the jump reaches the decoder. It then expects `miss_flag` to stay high. Just before that, it issues a clear with no miss pending and expects the flag to drop, so the two outcomes can be told apart.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   typedef enum logic [1:0] {
      STEP_NONE,
      STEP_FWD,
      STEP_BWD,
      STEP_JUMP
   } step_e;

   // position on the four-state ring 00,01,11,10
   function automatic logic [1:0] ring_pos(input logic [1:0] ab);
      return {ab[1], ab[1] ^ ab[0]};
   endfunction

   function automatic step_e classify(input logic [1:0] old_ab, input logic [1:0] new_ab);
      logic [1:0] d;
      d = ring_pos(new_ab) - ring_pos(old_ab);
      case (d)
         2'd0:    return STEP_NONE;
         2'd1:    return STEP_FWD;
         2'd3:    return STEP_BWD;
         default: return STEP_JUMP;
      endcase
   endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qenc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/qenc_filter.sv
module qenc_filter #(
   parameter int FILT_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              din,
   input  logic [FILT_W-1:0] len,
   output logic              dout
);

   localparam logic [FILT_W-1:0] FILT_ONE = FILT_W'(1);

   logic [FILT_W-1:0] run;

   always_ff @(posedge clk) begin
      if (rst) begin
         dout <= 1'b0;
         run  <= '0;
      end else if (din == dout) begin
         run <= '0;
      end else if (run >= len) begin
         dout <= din;
         run  <= '0;
      end else begin
         run <= run + FILT_ONE;
      end
   end

   // R4
   filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (dout != $past(dout)) |-> ($past(din) != $past(dout)));

endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
   import qenc_pkg::*;
#(
   parameter int MISS_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              both_edges,
   input  logic              transparent,
   input  logic              fix_en,
   input  logic [MISS_W-1:0] miss_lim,
   input  logic              miss_clr,
   input  logic              ph_a,
   input  logic              ph_b,
   input  logic              ph_idx,
   output logic              up,
   output logic              dn,
   output logic              idx_pulse,
   output logic              dir_fwd,
   output logic              miss_flag
);

   localparam logic [MISS_W-1:0] RUN_MAX = '1;
   localparam logic [MISS_W-1:0] RUN_ONE = MISS_W'(1);

   logic [1:0]        ab_q;
   logic              idx_q;
   logic [MISS_W-1:0] run_q, run_n;
   step_e             step;
   logic              a_moved, any_moved;
   logic              up_n, dn_n, dir_n, set_n;

   always_comb begin
      step      = classify(ab_q, {ph_a, ph_b});
      a_moved   = (ph_a != ab_q[1]);
      any_moved = ({ph_a, ph_b} != ab_q);
      up_n      = 1'b0;
      dn_n      = 1'b0;
      dir_n     = dir_fwd;
      set_n     = 1'b0;
      run_n     = run_q;
      if (!en) begin
         run_n = '0;
      end else if (transparent) begin
         up_n = both_edges ? any_moved : a_moved;
         if (any_moved) run_n = '0;
      end else begin
         case (step)
            STEP_FWD: begin
               up_n  = both_edges | a_moved;
               dir_n = 1'b1;
               run_n = '0;
            end
            STEP_BWD: begin
               dn_n  = both_edges | a_moved;
               dir_n = 1'b0;
               run_n = '0;
            end
            STEP_JUMP: begin
               if (fix_en) begin
                  up_n  = dir_fwd;
                  dn_n  = ~dir_fwd;
                  run_n = (run_q == RUN_MAX) ? run_q : run_q + RUN_ONE;
                  set_n = (miss_lim != '0) && (run_n >= miss_lim);
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ab_q      <= 2'b00;
         idx_q     <= 1'b0;
         run_q     <= '0;
         up        <= 1'b0;
         dn        <= 1'b0;
         idx_pulse <= 1'b0;
         dir_fwd   <= 1'b1;
         miss_flag <= 1'b0;
      end else begin
         ab_q      <= {ph_a, ph_b};
         idx_q     <= ph_idx;
         run_q     <= run_n;
         up        <= up_n;
         dn        <= dn_n;
         dir_fwd   <= dir_n;
         idx_pulse <= en & ph_idx & ~idx_q;
         if (set_n)         miss_flag <= 1'b1;
         else if (miss_clr) miss_flag <= 1'b0;
      end
   end

   // R6
   up_dn_excl_chk: assert property (@(posedge clk) disable iff (rst) !(up && dn));

   // R8
   transp_no_down_chk: assert property (@(posedge clk) disable iff (rst)
      $past(transparent) |-> !dn);

   // R10
   off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(en) |-> (!up && !dn && !idx_pulse));

   // R9
   idx_single_chk: assert property (@(posedge clk) disable iff (rst)
      idx_pulse |=> !idx_pulse);

   // R12
   lim_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(miss_flag) |-> ($past(miss_lim) != '0));

   // R13
   flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(miss_flag) && !$past(miss_clr)) |-> miss_flag);

endmodule

// File: rtl/qenc_front.sv
module qenc_front #(
   parameter int FILT_W      = 6,
   parameter int MISS_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_IDX  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cfg_we,
   input  logic [9+FILT_W+MISS_W-1:0] cfg_wdata,
   input  logic                     miss_clr,
   input  logic                     enc_a,
   input  logic                     enc_b,
   input  logic                     enc_idx,
   output logic                     cnt_up,
   output logic                     cnt_dn,
   output logic                     idx_pulse,
   output logic                     dir_fwd,
   output logic                     miss_flag
);

   localparam int FLAG_BITS = 9;
   localparam int FILT_LSB  = FLAG_BITS;
   localparam int MISS_LSB  = FLAG_BITS + FILT_W;
   localparam int CFG_W     = FLAG_BITS + FILT_W + MISS_W;
   localparam int NCH       = 3;

   generate
      if (FILT_W < 1 || FILT_W > 16) begin : g_bad_filt
         $error("qenc_front: FILT_W out of range 1..16");
      end
      if (MISS_W < 1 || MISS_W > 8) begin : g_bad_miss
         $error("qenc_front: MISS_W out of range 1..8");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk) begin
      if (rst)         cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end

   logic              c_en, c_both, c_transp, c_swap, c_inv_a, c_inv_b, c_inv_idx, c_idx_sel, c_fix;
   logic [FILT_W-1:0] c_len;
   logic [MISS_W-1:0] c_lim;

   assign c_en      = cfg_q[0];
   assign c_both    = cfg_q[1];
   assign c_transp  = cfg_q[2];
   assign c_swap    = cfg_q[3];
   assign c_inv_a   = cfg_q[4];
   assign c_inv_b   = cfg_q[5];
   assign c_inv_idx = cfg_q[6];
   assign c_idx_sel = cfg_q[7];
   assign c_fix     = cfg_q[8];
   assign c_len     = cfg_q[FILT_LSB +: FILT_W];
   assign c_lim     = cfg_q[MISS_LSB +: MISS_W];

   // conditioning: invert first, then swap, index select from raw pins
   logic a_inv, b_inv;
   logic [NCH-1:0] cond, synced, filt;

   always_comb begin
      a_inv   = enc_a ^ c_inv_a;
      b_inv   = enc_b ^ c_inv_b;
      cond[0] = c_swap ? b_inv : a_inv;
      cond[1] = c_swap ? a_inv : b_inv;
      cond[2] = (c_idx_sel ? enc_b : enc_idx) ^ c_inv_idx;
   end

   qenc_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (cond),
      .q   (synced)
   );

   generate
      for (genvar c = 0; c < 2; c++) begin : g_phase_filt
         qenc_filter #(.FILT_W(FILT_W)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (synced[c]),
            .len  (c_len),
            .dout (filt[c])
         );
      end
      if (FILTER_IDX) begin : g_idx_filt
         qenc_filter #(.FILT_W(FILT_W)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (synced[2]),
            .len  (c_len),
            .dout (filt[2])
         );
      end else begin : g_idx_raw
         assign filt[2] = synced[2];
      end
   endgenerate

   qenc_decoder #(.MISS_W(MISS_W)) u_dec (
      .clk         (clk),
      .rst         (rst),
      .en          (c_en),
      .both_edges  (c_both),
      .transparent (c_transp),
      .fix_en      (c_fix),
      .miss_lim    (c_lim),
      .miss_clr    (miss_clr),
      .ph_a        (filt[0]),
      .ph_b        (filt[1]),
      .ph_idx      (filt[2]),
      .up          (cnt_up),
      .dn          (cnt_dn),
      .idx_pulse   (idx_pulse),
      .dir_fwd     (dir_fwd),
      .miss_flag   (miss_flag)
   );

endmodule

// File: tb/tb_qenc_front.sv
module tb_qenc_front;

   localparam int CW = 19;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [CW-1:0] cfg_wdata = '0;
   logic          miss_clr = 1'b0;
   logic          enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
   logic          cnt_up, cnt_dn, idx_pulse, dir_fwd, miss_flag;

   always #2 clk = ~clk;

   qenc_front dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .miss_clr(miss_clr), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
      .cnt_up(cnt_up), .cnt_dn(cnt_dn), .idx_pulse(idx_pulse),
      .dir_fwd(dir_fwd), .miss_flag(miss_flag)
   );

   int n_chk = 0, n_fail = 0;
   int n_up = 0, n_dn = 0, n_idx = 0;
   int base_up = 0, base_dn = 0, base_idx = 0;
   int eu = 0, ed = 0;
   bit edir = 1'b1;
   bit m_both, m_transp, m_swap, m_ia, m_ib, m_fix;
   int cur_l = 0;
   logic pa = 1'b0, pb = 1'b0;

   always @(negedge clk) if (!rst) begin
      if (cnt_up)    n_up++;
      if (cnt_dn)    n_dn++;
      if (idx_pulse) n_idx++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] mk(bit en, bit both, bit tr, bit sw, bit ia, bit ib,
                                        bit ii, bit isel, bit fix, int len, int lim);
      logic [CW-1:0] v;
      v = '0;
      v[0] = en; v[1] = both; v[2] = tr; v[3] = sw; v[4] = ia;
      v[5] = ib; v[6] = ii; v[7] = isel; v[8] = fix;
      v[14:9]  = len[5:0];
      v[18:15] = lim[3:0];
      return v;
   endfunction

   function automatic int gpos(logic a, logic b);
      case ({a, b})
         2'b00: return 0;
         2'b01: return 1;
         2'b11: return 2;
         default: return 3;
      endcase
   endfunction

   function automatic logic [1:0] pos_pins(int p);
      case (p)
         0: return 2'b00;
         1: return 2'b01;
         2: return 2'b11;
         default: return 2'b10;
      endcase
   endfunction

   function automatic logic [1:0] cond(logic a, logic b);
      logic xa, xb;
      xa = a ^ m_ia;
      xb = b ^ m_ib;
      return m_swap ? {xb, xa} : {xa, xb};
   endfunction

   task automatic settle();
      repeat (cur_l + 10) @(negedge clk);
   endtask

   task automatic write_cfg(input logic [CW-1:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic snap();
      base_up = n_up; base_dn = n_dn; base_idx = n_idx;
      eu = 0; ed = 0;
   endtask

   task automatic reconfig(input logic [CW-1:0] v);
      logic [CW-1:0] off;
      off = v;
      off[0] = 1'b0;
      write_cfg(off);
      cur_l = int'(v[14:9]);
      m_both = v[1]; m_transp = v[2]; m_swap = v[3];
      m_ia = v[4]; m_ib = v[5]; m_fix = v[8];
      settle();
      @(negedge clk); miss_clr = 1'b1;
      @(negedge clk); miss_clr = 1'b0;
      write_cfg(v);
      repeat (4) @(negedge clk);
      snap();
   endtask

   task automatic model_step(input logic na, input logic nb);
      logic [1:0] o, x;
      int d;
      bit amv;
      o = cond(pa, pb);
      x = cond(na, nb);
      d = (gpos(x[1], x[0]) - gpos(o[1], o[0]) + 4) % 4;
      amv = (o[1] != x[1]);
      if (m_transp) begin
         if (m_both ? (d != 0) : amv) eu++;
      end else if (d == 1) begin
         if (m_both || amv) eu++;
         edir = 1'b1;
      end else if (d == 3) begin
         if (m_both || amv) ed++;
         edir = 1'b0;
      end else if (d == 2 && m_fix) begin
         if (edir) eu++; else ed++;
      end
      pa = na;
      pb = nb;
   endtask

   task automatic step_to(input logic na, input logic nb);
      model_step(na, nb);
      @(negedge clk);
      enc_a = na;
      enc_b = nb;
      repeat (cur_l + 3 + int'($urandom % 3)) @(negedge clk);
   endtask

   task automatic drive_raw(input logic na, input logic nb, input logic ni);
      @(negedge clk);
      enc_a = na; enc_b = nb; enc_idx = ni;
      pa = na; pb = nb;
      repeat (cur_l + 6) @(negedge clk);
   endtask

   task automatic chk_counts(input string req);
      settle();
      chk({req, " up"}, n_up - base_up, eu);
      chk({req, " down"}, n_dn - base_dn, ed);
   endtask

   task automatic fwd4();
      for (int i = 0; i < 4; i++) begin
         logic [1:0] p;
         p = pos_pins((gpos(pa, pb) + 1) % 4);
         step_to(p[1], p[0]);
      end
   endtask

   task automatic bwd4();
      for (int i = 0; i < 4; i++) begin
         logic [1:0] p;
         p = pos_pins((gpos(pa, pb) + 3) % 4);
         step_to(p[1], p[0]);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk("R1 cnt_up", int'(cnt_up), 0);
      chk("R1 cnt_dn", int'(cnt_dn), 0);
      chk("R1 idx_pulse", int'(idx_pulse), 0);
      chk("R1 miss_flag", int'(miss_flag), 0);
      chk("R1 dir_fwd", int'(dir_fwd), 1);
      // R1 R10: decoder is off after reset, pin activity gives nothing
      snap();
      drive_raw(1'b0, 1'b1, 1'b1);
      drive_raw(1'b0, 1'b0, 1'b0);
      chk("R1 idle up", n_up - base_up, 0);

      // R2 R6 forward then backward, both edges
      reconfig(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 2, 0));
      fwd4();
      chk_counts("R2 R6 fwd");
      chk("R6 dir fwd", int'(dir_fwd), 1);
      bwd4();
      chk_counts("R6 bwd");
      chk("R6 dir bwd", int'(dir_fwd), 0);

      // R7 phase A edges only
      reconfig(mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0));
      fwd4();
      chk_counts("R7 a-only");
      chk("R7 a-only total", n_up - base_up, 2);

      // R3 swap reverses the sense
      reconfig(mk(1, 1, 0, 1, 0, 0, 0, 0, 0, 2, 0));
      fwd4();
      chk_counts("R3 swap");
      chk("R3 swap down", n_dn - base_dn, 4);

      // R3 inversion of A reverses the sense
      reconfig(mk(1, 1, 0, 0, 1, 0, 0, 0, 0, 2, 0));
      fwd4();
      chk_counts("R3 inv_a");
      chk("R3 inv_a down", n_dn - base_dn, 4);

      // R4 filter: L=3, width 3 rejected, width 4 accepted
      reconfig(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 3, 0));
      @(negedge clk); enc_b = 1'b1;
      repeat (3) @(negedge clk);
      enc_b = 1'b0;
      settle();
      chk("R4 short pulse up", n_up - base_up, 0);
      chk("R4 short pulse down", n_dn - base_dn, 0);
      @(negedge clk); enc_b = 1'b1;
      repeat (4) @(negedge clk);
      enc_b = 1'b0;
      settle();
      chk("R4 wide pulse up", n_up - base_up, 1);
      chk("R4 wide pulse down", n_dn - base_dn, 1);

      // R5 latency with L=2: strobe after edge 6
      reconfig(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 2, 0));
      model_step(1'b0, 1'b1);
      @(negedge clk); enc_b = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R5 before", int'(cnt_up), 0);
      @(posedge clk); @(negedge clk);
      chk("R5 at", int'(cnt_up), 1);
      @(posedge clk); @(negedge clk);
      chk("R5 after", int'(cnt_up), 0);
      step_to(1'b0, 1'b0);
      chk_counts("R5 total");

      // R8 transparent: backward motion gives only up strobes, dir held
      begin
         bit d0;
         reconfig(mk(1, 1, 1, 0, 0, 0, 0, 0, 0, 2, 0));
         d0 = dir_fwd;
         bwd4();
         chk_counts("R8 transparent");
         chk("R8 dir held", int'(dir_fwd), int'(d0));
         chk("R8 no down", n_dn - base_dn, 0);
      end

      // R9 index from its own pin
      reconfig(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 2, 0));
      drive_raw(pa, pb, 1'b1);
      drive_raw(pa, pb, 1'b1);
      drive_raw(pa, pb, 1'b0);
      settle();
      chk("R9 own pin", n_idx - base_idx, 1);
      // R9 index taken from phase B pin
      reconfig(mk(1, 1, 0, 0, 0, 0, 0, 1, 0, 2, 0));
      drive_raw(pa, pb, 1'b1);
      drive_raw(pa, pb, 1'b0);
      chk("R9 sel ignores idx pin", n_idx - base_idx, 0);
      step_to(1'b0, 1'b1);
      settle();
      chk("R9 sel from B", n_idx - base_idx, 1);
      step_to(1'b0, 1'b0);
      // R9 inverted index: falling pin edge pulses
      reconfig(mk(1, 1, 0, 0, 0, 0, 1, 0, 0, 2, 0));
      drive_raw(pa, pb, 1'b1);
      chk("R9 inv rise", n_idx - base_idx, 0);
      drive_raw(pa, pb, 1'b0);
      settle();
      chk("R9 inv fall", n_idx - base_idx, 1);

      // R10 disabled
      write_cfg(mk(0, 1, 0, 0, 0, 0, 0, 0, 1, 2, 1));
      settle();
      snap();
      drive_raw(1'b0, 1'b1, 1'b1);
      drive_raw(1'b1, 1'b0, 1'b0);
      drive_raw(1'b0, 1'b0, 1'b1);
      drive_raw(1'b0, 1'b0, 1'b0);
      settle();
      chk("R10 up", n_up - base_up, 0);
      chk("R10 down", n_dn - base_dn, 0);
      chk("R10 idx", n_idx - base_idx, 0);
      chk("R10 flag", int'(miss_flag), 0);

      // R11 R12 miss with correction, threshold 2
      reconfig(mk(1, 1, 0, 0, 0, 0, 0, 0, 1, 2, 2));
      step_to(1'b0, 1'b1);
      step_to(1'b1, 1'b0);
      settle();
      chk("R12 one miss", int'(miss_flag), 0);
      step_to(1'b0, 1'b1);
      settle();
      chk("R12 two misses", int'(miss_flag), 1);
      chk_counts("R11 corrected");
      @(negedge clk); miss_clr = 1'b1;
      @(negedge clk); miss_clr = 1'b0;
      chk("R13 clear", int'(miss_flag), 0);

      // R12 valid step resets run; R13 set wins over clear
      reconfig(mk(1, 1, 0, 0, 0, 0, 0, 0, 1, 2, 2));
      step_to(1'b1, 1'b0);
      step_to(1'b0, 1'b0);
      step_to(1'b1, 1'b1);
      settle();
      chk("R12 run reset", int'(miss_flag), 0);
      step_to(1'b0, 1'b0);
      settle();
      chk("R12 run 2", int'(miss_flag), 1);
      @(negedge clk); miss_clr = 1'b1;
      @(negedge clk); miss_clr = 1'b0;
      chk("R13 clear only", int'(miss_flag), 0);
      model_step(1'b1, 1'b1);
      @(negedge clk); enc_a = 1'b1; enc_b = 1'b1;
      repeat (3 + cur_l) @(posedge clk);
      @(negedge clk); miss_clr = 1'b1;
      @(posedge clk);
      @(negedge clk); miss_clr = 1'b0;
      settle();
      chk("R13 set wins", int'(miss_flag), 1);
      chk_counts("R11 R12 sequence");

      // R12 threshold zero never flags
      reconfig(mk(1, 1, 0, 0, 0, 0, 0, 0, 1, 2, 0));
      step_to(1'b0, 1'b0);
      step_to(1'b1, 1'b1);
      step_to(1'b0, 1'b0);
      settle();
      chk("R12 lim0 flag", int'(miss_flag), 0);
      chk_counts("R12 lim0");

      // R11 handling disabled: jumps give nothing
      reconfig(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 2, 1));
      step_to(1'b1, 1'b1);
      step_to(1'b0, 1'b0);
      settle();
      chk("R11 off up", n_up - base_up, 0);
      chk("R11 off down", n_dn - base_dn, 0);
      chk("R11 off flag", int'(miss_flag), 0);

      // R3 R6 R7 random legal walks under random conditioning
      for (int blk = 0; blk < 8; blk++) begin
         bit moved;
         reconfig(mk(1, bit'($urandom % 2), 0, bit'($urandom % 2), bit'($urandom % 2),
                     bit'($urandom % 2), 0, 0, 0, 1 + int'($urandom % 5), 0));
         moved = 1'b0;
         for (int i = 0; i < 40; i++) begin
            logic [1:0] p;
            if ($urandom % 2) p = pos_pins((gpos(pa, pb) + 1) % 4);
            else              p = pos_pins((gpos(pa, pb) + 3) % 4);
            step_to(p[1], p[0]);
            moved = 1'b1;
         end
         chk_counts("R6 R7 random");
         if (moved) chk("R6 random dir", int'(dir_fwd), int'(edir));
      end

      summary();
      $finish;
   end

endmodule